// File: doc/BRIEF.md
# Modem Control and Status Logic

This block covers the modem side of one serial channel. Two active-low handshake outputs, data-terminal-ready and request-to-send, follow bits in a control register. A third active-low auxiliary output follows another control bit. The four active-low handshake inputs (clear-to-send, data-set-ready, ring indicator and carrier detect) are synchronised into the clock domain. They then appear in a status register, next to sticky change flags.

An active-high interrupt request is raised while a change flag is pending and the modem interrupt is enabled. The block can also hold back the start of the next character while clear-to-send is inactive. It does this through a launch qualifier that sits between the transmitter's "character waiting" and "shifter idle" signals. A character that is already leaving the shifter is never cut short.

Top module: `modem_ctl`

## Requirements
- R1: Writing address 0 (control) with bit 0 = 1 drives `dtr_n` low. Bit 0 = 0, or reset, drives it high.
- R2: Control bit 1 = 1 drives `rts_n` low. Bit 1 = 0, or reset, drives it high.
- R3: Control bit 3 resets to 1, so the control register reads 0x08 after reset. `aux_n` is low while bit 3 is 1 and high while it is 0.
- R4: Status register (address 1) bits 7..4 read the synchronised, inverted levels of carrier detect, ring, data-set-ready and clear-to-send. Bit 4 is clear-to-send, bit 5 is data-set-ready, bit 6 is ring and bit 7 is carrier detect.
- R5: Status bits 0, 1 and 3 are sticky change flags. They are set by any transition of clear-to-send, data-set-ready and carrier detect respectively.
- R6: Status bit 2 is set only when `ri_n` returns from 0 to 1. A 1-to-0 transition of `ri_n` leaves it unchanged.
- R7: Reading the status register clears all change flags. A change detected in the same cycle as the read is kept and appears on the next read.
- R8: `irq` is high exactly while bit 0 of the interrupt-enable register (address 2) is 1 and at least one change flag is set.
- R9: When control bit 5 (auto clear-to-send) is 1, `tx_launch` is low while synchronised `cts_n` is high. When bit 5 is 0, `cts_n` has no effect on `tx_launch`. Otherwise `tx_launch` = `tx_pending` AND `tx_idle`.
- R10: Writes to the status address are ignored. Address 3 reads 0. The control and enable registers read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (clears change flags at address 1) |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from `addr` |
| cts_n | input | 1 | Clear-to-send, active low |
| dsr_n | input | 1 | Data-set-ready, active low |
| ri_n | input | 1 | Ring indicator, active low |
| cd_n | input | 1 | Carrier detect, active low |
| dtr_n | output | 1 | Data-terminal-ready, active low |
| rts_n | output | 1 | Request-to-send, active low |
| aux_n | output | 1 | Auxiliary output, active low |
| irq | output | 1 | Modem-status interrupt request, active high |
| tx_pending | input | 1 | Transmitter has a character waiting |
| tx_idle | input | 1 | Transmit shifter is idle |
| tx_launch | output | 1 | Permission to start the next character |

## Verification
The bench builds the block with `SYNC_STAGES = 3`, one stage deeper than the default. Every latency in the checks therefore depends on the parameter and not on a hard-coded two-flop chain. With the edge count known, the bench can place a status read in exactly the cycle where a clear-to-send change leaves the last synchroniser stage. This exercises the read-versus-set collision. The ring flag is exercised on both edges of `ri_n`, and the launch gate is exercised with auto clear-to-send both off and on.

// File: rtl/mdm_pkg.sv
package mdm_pkg;
  localparam int ADDR_W  = 2;
  localparam int DATA_W  = 8;
  localparam int NLINES  = 4;

  localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] A_STAT = 2'd1;
  localparam logic [ADDR_W-1:0] A_IEN  = 2'd2;

  // line order inside status nibbles
  localparam int L_CTS = 0;
  localparam int L_DSR = 1;
  localparam int L_RI  = 2;
  localparam int L_CD  = 3;

  // control bit positions
  localparam int C_DTR  = 0;
  localparam int C_RTS  = 1;
  localparam int C_AUX  = 3;
  localparam int C_ACTS = 5;
  localparam logic [DATA_W-1:0] CTRL_RST = 8'h08;
endpackage

// File: rtl/mdm_rst_sync.sv
module mdm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_s_n = chain_q[STAGES-1];
endmodule

// File: rtl/mdm_in_sync.sv
module mdm_in_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 4
) (
  input  logic             clk,
  input  logic             rst_s_n,
  input  logic [WIDTH-1:0] pin_n,
  output logic [WIDTH-1:0] sync_n
);
  logic [WIDTH-1:0] stage_q [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      logic [WIDTH-1:0] d;
      if (g == 0) begin : g_first
        assign d = pin_n;
      end else begin : g_rest
        assign d = stage_q[g-1];
      end
      always_ff @(posedge clk or negedge rst_s_n) begin
        if (!rst_s_n) stage_q[g] <= '1;
        else          stage_q[g] <= d;
      end
    end
  endgenerate

  assign sync_n = stage_q[STAGES-1];
endmodule

// File: rtl/mdm_status.sv
module mdm_status
  import mdm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_s_n,
  input  logic [NLINES-1:0] lvl,
  input  logic              clr,
  output logic [NLINES-1:0] delta
);
  logic [NLINES-1:0] prev_q, delta_q, delta_d, hit;

  genvar g;
  generate
    for (g = 0; g < NLINES; g++) begin : g_line
      if (g == L_RI) begin : g_trail
        assign hit[g] = prev_q[g] & ~lvl[g];
      end else begin : g_any
        assign hit[g] = prev_q[g] ^ lvl[g];
      end
    end
  endgenerate

  always_comb begin
    delta_d = (clr ? '0 : delta_q) | hit;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      prev_q  <= '0;
      delta_q <= '0;
    end else begin
      prev_q  <= lvl;
      delta_q <= delta_d;
    end
  end

  assign delta = delta_q;

  // R5: a clear-to-send edge leaves its flag set
  p_cts_flag_r5: assert property (@(posedge clk) disable iff (!rst_s_n)
    (lvl[L_CTS] != prev_q[L_CTS]) |=> delta_q[L_CTS]);
  // R6: ring going active never creates a flag
  p_ri_lead_r6: assert property (@(posedge clk) disable iff (!rst_s_n)
    (lvl[L_RI] && !prev_q[L_RI] && !clr) |=> (delta_q[L_RI] == $past(delta_q[L_RI])));
  // R7: a quiet read leaves no flag behind
  p_read_clear_r7: assert property (@(posedge clk) disable iff (!rst_s_n)
    (clr && lvl == prev_q) |=> (delta_q == '0));
endmodule

// File: rtl/modem_ctl.sv
module modem_ctl
  import mdm_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              cts_n,
  input  logic              dsr_n,
  input  logic              ri_n,
  input  logic              cd_n,
  output logic              dtr_n,
  output logic              rts_n,
  output logic              aux_n,
  output logic              irq,
  input  logic              tx_pending,
  input  logic              tx_idle,
  output logic              tx_launch
);
  logic              rst_s_n;
  logic [NLINES-1:0] pins_n, sync_n, lvl, delta;
  logic [DATA_W-1:0] ctrl_q, ctrl_d, ien_q, ien_d;
  logic              ctrl_we, ien_we, stat_rd, cts_ok;

  mdm_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_s_n(rst_s_n));

  assign pins_n = {cd_n, ri_n, dsr_n, cts_n};

  mdm_in_sync #(.STAGES(SYNC_STAGES), .WIDTH(NLINES)) u_sync (
    .clk(clk), .rst_s_n(rst_s_n), .pin_n(pins_n), .sync_n(sync_n));

  assign lvl = ~sync_n;

  assign stat_rd = rd_en && (addr == A_STAT);

  mdm_status u_stat (
    .clk(clk), .rst_s_n(rst_s_n), .lvl(lvl), .clr(stat_rd), .delta(delta));

  // register writes: explicit enables
  assign ctrl_we = wr_en && (addr == A_CTRL);
  assign ien_we  = wr_en && (addr == A_IEN);

  always_comb begin
    ctrl_d = ctrl_we ? wdata : ctrl_q;
    ien_d  = ien_we  ? wdata : ien_q;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      ctrl_q <= CTRL_RST;
      ien_q  <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      ien_q  <= ien_d;
    end
  end

  always_comb begin
    unique case (addr)
      A_CTRL:  rdata = ctrl_q;
      A_STAT:  rdata = {lvl, delta};
      A_IEN:   rdata = ien_q;
      default: rdata = '0;
    endcase
  end

  assign dtr_n = ~ctrl_q[C_DTR];
  assign rts_n = ~ctrl_q[C_RTS];
  assign aux_n = ~ctrl_q[C_AUX];
  assign irq   = ien_q[0] && (delta != '0);

  assign cts_ok    = !ctrl_q[C_ACTS] || lvl[L_CTS];
  assign tx_launch = tx_pending && tx_idle && cts_ok;

  // R1: a control write lands on dtr_n one edge later
  p_dtr_write_r1: assert property (@(posedge clk) disable iff (!rst_s_n)
    ctrl_we |=> (dtr_n == !$past(wdata[C_DTR])));
  // R2: same for rts_n
  p_rts_write_r2: assert property (@(posedge clk) disable iff (!rst_s_n)
    ctrl_we |=> (rts_n == !$past(wdata[C_RTS])));
  // R9: no launch while flow control holds the line
  p_cts_gate_r9: assert property (@(posedge clk) disable iff (!rst_s_n)
    (ctrl_q[C_ACTS] && sync_n[L_CTS]) |-> !tx_launch);
  // R8: interrupt never raised with no pending flag
  p_irq_src_r8: assert property (@(posedge clk) disable iff (!rst_s_n)
    irq |-> (delta != '0));
endmodule

// File: tb/modem_ctl_tb.sv
module modem_ctl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n, wr_en, rd_en, cts_n, dsr_n, ri_n, cd_n, tx_pending, tx_idle;
  logic [1:0] addr;
  logic [7:0] wdata, rdata;
  logic       dtr_n, rts_n, aux_n, irq, tx_launch;
  logic       probe;

  typedef struct {
    int         sel;
    logic [7:0] exp;
    string      req;
  } item_t;

  item_t q[$];
  int applied = 0;
  int bad = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  modem_ctl #(.SYNC_STAGES(3)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .cts_n(cts_n), .dsr_n(dsr_n), .ri_n(ri_n),
    .cd_n(cd_n), .dtr_n(dtr_n), .rts_n(rts_n), .aux_n(aux_n), .irq(irq),
    .tx_pending(tx_pending), .tx_idle(tx_idle), .tx_launch(tx_launch));

  function automatic logic [7:0] observe(int sel);
    case (sel)
      0: return rdata;
      1: return {7'd0, dtr_n};
      2: return {7'd0, rts_n};
      3: return {7'd0, aux_n};
      4: return {7'd0, irq};
      default: return {7'd0, tx_launch};
    endcase
  endfunction

  // monitor: pops the scoreboard when a probe is open
  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (probe) begin
      if (q.size() == 0) begin
        bad <= bad + 1;
        $display("FAIL scoreboard empty: actual %02h expected item", rdata);
      end else begin
        item_t it;
        logic [7:0] act;
        it = q.pop_front();
        act = observe(it.sel);
        applied <= applied + 1;
        if (act !== it.exp) begin
          bad <= bad + 1;
          $display("FAIL %s: sel %0d actual %02h expected %02h", it.req, it.sel, act, it.exp);
        end
      end
    end
  end

  task automatic idle(int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(posedge clk); #2;
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk); #2;
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, logic [7:0] e, string req);
    @(posedge clk); #2;
    addr = a; rd_en = 1'b1; probe = 1'b1;
    q.push_back('{sel: 0, exp: e, req: req});
    @(posedge clk); #2;
    rd_en = 1'b0; probe = 1'b0;
  endtask

  task automatic pin(int sel, logic e, string req);
    @(posedge clk); #2;
    addr = 2'd3; probe = 1'b1;
    q.push_back('{sel: sel, exp: {7'd0, e}, req: req});
    @(posedge clk); #2;
    probe = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 0; rd_en = 0; addr = 0; wdata = 0; probe = 0;
    cts_n = 1; dsr_n = 1; ri_n = 1; cd_n = 1; tx_pending = 0; tx_idle = 0;
    idle(3); #2 rst_n = 1'b1;
    idle(4);

    // reset state
    pin(1, 1'b1, "R1 dtr_n after reset");
    pin(2, 1'b1, "R2 rts_n after reset");
    pin(3, 1'b0, "R3 aux_n after reset");
    rd(2'd0, 8'h08, "R3 control reset value");
    rd(2'd1, 8'h00, "R4 status after reset");
    pin(4, 1'b0, "R8 irq after reset");
    rd(2'd3, 8'h00, "R10 unused address");

    // outputs from control
    wr(2'd0, 8'h03);
    pin(1, 1'b0, "R1 dtr_n set");
    pin(2, 1'b0, "R2 rts_n set");
    pin(3, 1'b1, "R3 aux_n with bit3 clear");
    rd(2'd0, 8'h03, "R10 control readback");
    wr(2'd0, 8'h08);
    pin(1, 1'b1, "R1 dtr_n cleared");
    pin(2, 1'b1, "R2 rts_n cleared");

    // CTS change
    cts_n = 1'b0; idle(6);
    rd(2'd1, 8'h11, "R5 cts delta and R4 level");
    rd(2'd1, 8'h10, "R7 cleared by read");

    // DSR and CD
    dsr_n = 1'b0; cd_n = 1'b0; idle(6);
    rd(2'd1, 8'hBA, "R5 dsr/cd delta");
    rd(2'd1, 8'hB0, "R7 cleared again");

    // ring edges
    ri_n = 1'b0; idle(6);
    rd(2'd1, 8'hF0, "R6 ring leading edge gives no flag");
    ri_n = 1'b1; idle(6);
    rd(2'd1, 8'hB4, "R6 ring trailing edge flag");
    rd(2'd1, 8'hB0, "R7 ring flag cleared");

    // interrupt
    wr(2'd2, 8'h01);
    pin(4, 1'b0, "R8 irq enabled, no flags");
    rd(2'd2, 8'h01, "R10 enable readback");
    cd_n = 1'b1; idle(6);
    pin(4, 1'b1, "R8 irq on cd change");
    rd(2'd1, 8'h38, "R5 cd delta");
    pin(4, 1'b0, "R8 irq dropped after read");
    wr(2'd2, 8'h00);
    dsr_n = 1'b1; idle(6);
    pin(4, 1'b0, "R8 irq masked");
    rd(2'd1, 8'h12, "R5 dsr delta while masked");

    // read in the cycle the change emerges (3 sync stages)
    @(posedge clk); #2 cts_n = 1'b1;
    idle(2);
    rd(2'd1, 8'h00, "R7 collision read");
    rd(2'd1, 8'h01, "R7 collision change kept");

    // transmit launch gating
    tx_pending = 1'b1; tx_idle = 1'b1;
    pin(5, 1'b1, "R9 auto off, cts inactive ignored");
    wr(2'd0, 8'h28);
    pin(5, 1'b0, "R9 held by cts");
    cts_n = 1'b0; idle(6);
    pin(5, 1'b1, "R9 released by cts");
    tx_idle = 1'b0;
    pin(5, 1'b0, "R9 shifter busy");
    tx_idle = 1'b1; tx_pending = 1'b0;
    pin(5, 1'b0, "R9 nothing pending");

    // status is read-only
    rd(2'd1, 8'h11, "R5 cts delta before write");
    wr(2'd1, 8'hFF);
    rd(2'd1, 8'h10, "R10 status write ignored");

    idle(3);
    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end

  // watchdog
  always @(posedge clk) begin
    if (cyc > 20000) begin
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", applied, bad + 1);
      $finish;
    end
  end
endmodule